// File: doc/BRIEF.md
# Locked Page Write Buffer

This unit sits behind a serial-bus slave front end and owns the write path into a 256-byte register-array model. The front end tells it when a write transfer begins, which select code was matched (the main array or the protection register), when the address byte and each data byte arrive, and when a STOP was seen, together with a flag saying whether that STOP fell in the bit slot right after an acknowledge. For each data byte the unit returns an accept/refuse decision, and it gathers accepted bytes in a 16-byte row buffer.

A STOP that qualifies starts a self-timed commit. The unit raises `busy` for a set number of clock cycles, and when that time is up it writes into the array only the buffer slots filled during the transfer. A write to the protection-register select code sets a one-time lock. From then on the lower half of the array (addresses 00h-7Fh) is refused for good. A write-control input, when high, refuses every write. A combinational read port shows the array contents at all times, whatever the write control and lock.

Top module: `pwb_top`

## Requirements
- R1: Data bytes of one transfer go to consecutive addresses in which only bits 3..0 step up, wrapping from xFh to x0h in the same 16-byte row; bits 7..4 keep the value the address byte gave them.
- R2: A commit starts only when `stopIn` arrives with `stopAligned`=1 and the latest data byte of the transfer was accepted. Any other STOP, or a new `txStart` in the middle of a transfer, throws the buffered bytes away and leaves the array unchanged.
- R3: While `wcIn`=1, every data byte is refused (`ackOk`=0) and no array location or lock state changes. This holds for both select codes.
- R4: Once the lock is set, a data byte aimed at an address with bit 7 = 0 is refused and that location keeps its value, whatever `wcIn` is. Addresses with bit 7 = 1 stay writable.
- R5: With `wcIn`=0 and the lock clear, a data byte in a transfer that has `lockSel`=1 is accepted whatever its address and data values are. A qualifying STOP then sets the lock at the end of the commit.
- R6: The lock is never cleared except by reset (power-up). After it is set, protection-register data bytes are refused.
- R7: After a qualifying STOP, `busy` is high for exactly COMMIT_CYCLES clock cycles. The array takes the new bytes on the edge where `busy` falls. While `busy` is high, all front-end strobes are ignored.
- R8: After reset every array byte reads FFh, the lock is clear, and `busy` and `ackValid` are low.
- R9: Only slots written in the current transfer are committed. The other bytes of the row keep their old values.
- R10: `rdData` always shows the array byte at `rdAddr` in the same cycle, whatever `wcIn` and the lock are.
- R11: `ackValid` pulses for exactly one cycle, in the cycle after each data byte strobe that follows an address byte, and is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-up reset |
| wcIn | input | 1 | Write control; high refuses all writes |
| txStart | input | 1 | Pulse: a write transfer begins (select code matched) |
| lockSel | input | 1 | With txStart: 1 = protection register, 0 = main array |
| addrValid | input | 1 | Pulse: address byte present on addrByte |
| addrByte | input | 8 | Start address of the transfer |
| dataValid | input | 1 | Pulse: data byte present on dataByte |
| dataByte | input | 8 | Write data byte |
| stopIn | input | 1 | Pulse: STOP seen on the bus |
| stopAligned | input | 1 | With stopIn: STOP fell right after an acknowledge slot |
| rdAddr | input | 8 | Read port address |
| rdData | output | 8 | Array byte at rdAddr |
| ackValid | output | 1 | One-cycle pulse: a decision for the last data byte is ready |
| ackOk | output | 1 | With ackValid: 1 = accept, 0 = refuse |
| busy | output | 1 | Commit timer running |

## Verification
The assertions assume the front end raises at most one of `txStart`, `addrValid`, `dataValid` and `stopIn` in any cycle, and that each strobe lasts exactly one cycle. One of the checks covers this assumption. The bench drives every strobe as a single-cycle pulse on the falling clock edge, with at least one idle cycle between pulses. It also keeps issuing strobes while a commit is running, to exercise the rule that they are ignored. Address and data values in protection-register transfers are chosen at random-looking values to show that they have no effect.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef struct packed {
    logic clearBuf;
    logic loadAddr;
    logic writeSlot;
    logic advance;
    logic commitMem;
    logic commitLock;
  } pwbStrobes_t;
endpackage

// File: rtl/pwb_data.sv
module pwb_data
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwbStrobes_t       stb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic              lockBit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] rowBuf [PAGE];
  logic [PAGE-1:0]   slotValid;
  logic [ADDR_W-1:0] ptr;
  logic [ROW_W-1:0]  rowTop;
  logic [PAGE_W-1:0] slotIdx;

  assign rowTop  = ptr[ADDR_W-1:PAGE_W];
  assign slotIdx = ptr[PAGE_W-1:0];
  assign curAddr = ptr;
  assign rdData  = memArr[rdAddr];

  // pointer and slot bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      slotValid <= '0;
    end else begin
      if (stb.loadAddr) ptr <= addrIn;
      else if (stb.advance) ptr <= {rowTop, slotIdx + PAGE_W'(1)};
      if (stb.clearBuf || stb.commitMem) slotValid <= '0;
      else if (stb.writeSlot) slotValid[slotIdx] <= 1'b1;
    end
  end

  // row buffer storage
  generate
    for (genvar s = 0; s < PAGE; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (stb.writeSlot && slotIdx == PAGE_W'(s)) rowBuf[s] <= dataIn;
      end
    end
  endgenerate

  // array model, erased to all ones at power-up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) memArr[a] <= '1;
    end else if (stb.commitMem) begin
      for (int s = 0; s < PAGE; s++) begin
        if (slotValid[s]) memArr[{rowTop, PAGE_W'(s)}] <= rowBuf[s];
      end
    end
  end

  // one-time lock, cleared only by power-up reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockBit <= 1'b0;
    else if (stb.commitLock) lockBit <= 1'b1;
  end
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int COMMIT_CYCLES = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wcIn,
  input  logic        txStart,
  input  logic        lockSel,
  input  logic        addrValid,
  input  logic        dataValid,
  input  logic        stopIn,
  input  logic        stopAligned,
  input  logic        addrTop,
  input  logic        lockBit,
  output pwbStrobes_t stb,
  output logic        ackValid,
  output logic        ackOk,
  output logic        busy
);
  localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_BUSY} state_t;

  state_t           state, nextState;
  logic             tgtLock;
  logic             lastAck;
  logic             lockArm;
  logic [CNT_W-1:0] cnt;
  logic             allow;
  logic             commitOk;
  logic             timerDone;

  assign allow     = !wcIn && (tgtLock ? !lockBit : !(lockBit && !addrTop));
  assign commitOk  = stopAligned && lastAck;
  assign timerDone = (state == S_BUSY) && (cnt == LAST);
  assign busy      = (state == S_BUSY);

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (txStart) begin
          stb.clearBuf = 1'b1;
          nextState    = S_ADDR;
        end
      end
      S_ADDR: begin
        if (txStart) stb.clearBuf = 1'b1;
        else if (addrValid) begin
          stb.loadAddr = 1'b1;
          nextState    = S_DATA;
        end else if (stopIn) begin
          stb.clearBuf = 1'b1;
          nextState    = S_IDLE;
        end
      end
      S_DATA: begin
        if (txStart) begin
          stb.clearBuf = 1'b1;
          nextState    = S_ADDR;
        end else if (dataValid) begin
          stb.writeSlot = allow && !tgtLock;
          stb.advance   = 1'b1;
        end else if (stopIn) begin
          if (commitOk) nextState = S_BUSY;
          else begin
            stb.clearBuf = 1'b1;
            nextState    = S_IDLE;
          end
        end
      end
      S_BUSY: begin
        if (timerDone) begin
          stb.commitMem  = 1'b1;
          stb.commitLock = lockArm;
          nextState      = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      tgtLock  <= 1'b0;
      lastAck  <= 1'b0;
      lockArm  <= 1'b0;
      cnt      <= '0;
      ackValid <= 1'b0;
      ackOk    <= 1'b0;
    end else begin
      state    <= nextState;
      ackValid <= 1'b0;
      ackOk    <= 1'b0;
      if (state != S_BUSY && txStart) begin
        tgtLock <= lockSel;
        lastAck <= 1'b0;
        lockArm <= 1'b0;
      end
      if (state == S_DATA && !txStart && dataValid) begin
        ackValid <= 1'b1;
        ackOk    <= allow;
        lastAck  <= allow;
        if (allow && tgtLock) lockArm <= 1'b1;
      end
      if (state == S_BUSY) cnt <= cnt + CNT_W'(1);
      else cnt <= '0;
    end
  end
endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int PAGE_W        = 4,
  parameter int COMMIT_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wcIn,
  input  logic              txStart,
  input  logic              lockSel,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrByte,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataByte,
  input  logic              stopIn,
  input  logic              stopAligned,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              ackValid,
  output logic              ackOk,
  output logic              busy
);
  pwbStrobes_t       stb;
  logic [ADDR_W-1:0] curAddr;
  logic              lockBit;

  pwb_ctrl #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wcIn       (wcIn),
    .txStart    (txStart),
    .lockSel    (lockSel),
    .addrValid  (addrValid),
    .dataValid  (dataValid),
    .stopIn     (stopIn),
    .stopAligned(stopAligned),
    .addrTop    (curAddr[ADDR_W-1]),
    .lockBit    (lockBit),
    .stb        (stb),
    .ackValid   (ackValid),
    .ackOk      (ackOk),
    .busy       (busy)
  );

  pwb_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .addrIn (addrByte),
    .dataIn (dataByte),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .curAddr(curAddr),
    .lockBit(lockBit)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int COMMIT_CYCLES = 40
) (
  input logic clk,
  input logic rstN,
  input logic wcIn,
  input logic txStart,
  input logic addrValid,
  input logic dataValid,
  input logic stopIn,
  input logic ackValid,
  input logic ackOk,
  input logic busy,
  input logic lockBit
);
  localparam int CNT_W = $clog2(COMMIT_CYCLES + 2);
  logic [CNT_W-1:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= '0;
    else if (busy) busyLen <= busyLen + CNT_W'(1);
    else busyLen <= '0;
  end

  // input assumption: strobes are exclusive
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({txStart, addrValid, dataValid, stopIn}) <= 1);

  p_ack_after_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(dataValid));

  p_ack_one_cycle_r11: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);

  p_wc_refuses_r3: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && $past(wcIn) |-> !ackOk);

  p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ackValid);

  p_busy_bounded_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyLen <= CNT_W'(COMMIT_CYCLES));

  p_busy_length_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == CNT_W'(COMMIT_CYCLES));

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(lockBit));
endmodule

bind pwb_top pwb_checker #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wcIn     (wcIn),
  .txStart  (txStart),
  .addrValid(addrValid),
  .dataValid(dataValid),
  .stopIn   (stopIn),
  .ackValid (ackValid),
  .ackOk    (ackOk),
  .busy     (busy),
  .lockBit  (lockBit)
);

// File: tb/sim_pwb_top.sv
module sim_pwb_top;
  localparam int N = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wcIn = 1'b0;
  logic       txStart = 1'b0;
  logic       lockSel = 1'b0;
  logic       addrValid = 1'b0;
  logic [7:0] addrByte = '0;
  logic       dataValid = 1'b0;
  logic [7:0] dataByte = '0;
  logic       stopIn = 1'b0;
  logic       stopAligned = 1'b0;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       ackValid, ackOk, busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwb_top #(.COMMIT_CYCLES(N)) u0 (
    .clk(clk), .rstN(rstN), .wcIn(wcIn), .txStart(txStart), .lockSel(lockSel),
    .addrValid(addrValid), .addrByte(addrByte), .dataValid(dataValid),
    .dataByte(dataByte), .stopIn(stopIn), .stopAligned(stopAligned),
    .rdAddr(rdAddr), .rdData(rdData), .ackValid(ackValid), .ackOk(ackOk),
    .busy(busy)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mMem [256];
  bit  mLock, mInXfer, mHaveAddr, mTgtLock, mLastAck, mLockPend;
  int  mPtr, mBusyCnt;
  bit  mAckV, mAckOk, mBusy;
  int  qAddr[$];
  int  qData[$];

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 8'hFF;
      mLock = 0; mInXfer = 0; mHaveAddr = 0; mTgtLock = 0; mLastAck = 0;
      mLockPend = 0; mPtr = 0; mBusyCnt = 0; mAckV = 0; mAckOk = 0; mBusy = 0;
      qAddr.delete(); qData.delete();
    end else begin
      mAckV = 0; mAckOk = 0;
      if (mBusyCnt > 0) begin
        mBusyCnt--;
        if (mBusyCnt == 0) begin
          foreach (qAddr[i]) mMem[qAddr[i]] = qData[i];
          if (mLockPend) mLock = 1;
          qAddr.delete(); qData.delete(); mLockPend = 0;
        end
      end else if (txStart) begin
        mInXfer = 1; mHaveAddr = 0; mTgtLock = lockSel; mLastAck = 0;
        mLockPend = 0; qAddr.delete(); qData.delete();
      end else if (addrValid && mInXfer && !mHaveAddr) begin
        mPtr = addrByte; mHaveAddr = 1;
      end else if (dataValid && mHaveAddr) begin
        bit ok;
        if (mTgtLock) ok = !wcIn && !mLock;
        else ok = !wcIn && !(mLock && mPtr < 128);
        mAckV = 1; mAckOk = ok; mLastAck = ok;
        if (ok && !mTgtLock) begin qAddr.push_back(mPtr); qData.push_back(dataByte); end
        if (ok && mTgtLock) mLockPend = 1;
        mPtr = (mPtr & 8'hF0) | ((mPtr + 1) & 8'h0F);
      end else if (stopIn && mInXfer) begin
        if (mHaveAddr && stopAligned && mLastAck) mBusyCnt = N;
        else begin qAddr.delete(); qData.delete(); mLockPend = 0; end
        mInXfer = 0; mHaveAddr = 0;
      end
      mBusy = (mBusyCnt > 0);
    end
    #2;
    if (rstN && !done) begin
      check("R7 busy vs model", busy, mBusy);
      check("R11 ackValid vs model", ackValid, mAckV);
      if (mAckV) check("R3/R4 ackOk vs model", ackOk, mAckOk);
      check("R10 rdData vs model", rdData, mMem[rdAddr]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulseStart(bit sel);
    @(negedge clk); txStart = 1; lockSel = sel;
    @(negedge clk); txStart = 0;
  endtask
  task automatic pulseAddr(int a);
    @(negedge clk); addrValid = 1; addrByte = 8'(a);
    @(negedge clk); addrValid = 0;
  endtask
  task automatic pulseData(int d, int expOk, string tag);
    @(negedge clk); dataValid = 1; dataByte = 8'(d);
    @(negedge clk); dataValid = 0;
    check({tag, " ackValid"}, ackValid, 1);
    check({tag, " ackOk"}, ackOk, expOk);
  endtask
  task automatic pulseStop(bit aligned);
    @(negedge clk); stopIn = 1; stopAligned = aligned;
    @(negedge clk); stopIn = 0; stopAligned = 0;
  endtask
  task automatic waitIdle(int expLen, string tag);
    int len = 0;
    while (busy && len < 1000) begin len++; @(negedge clk); end
    check(tag, len, expLen);
  endtask
  task automatic readAt(int a, int exp, string tag);
    @(negedge clk); rdAddr = 8'(a);
    #1 check(tag, rdData, exp);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8 reset state
    check("R8 busy after reset", busy, 0);
    check("R8 ackValid after reset", ackValid, 0);
    readAt(8'h00, 8'hFF, "R8 erased 00");
    readAt(8'hFF, 8'hFF, "R8 erased FF");

    // byte write with busy timing (R7, R2)
    pulseStart(0); pulseAddr(8'h90); pulseData(8'h5A, 1, "R11 byte write");
    pulseStop(1);
    check("R7 busy raised", busy, 1);
    readAt(8'h90, 8'hFF, "R7 old value while busy");
    waitIdle(N - 1, "R7 busy length");
    readAt(8'h90, 8'h5A, "R2 committed byte");

    // page wrap inside row (R1, R9)
    pulseStart(0); pulseAddr(8'h9E);
    pulseData(8'h11, 1, "R1 p0"); pulseData(8'h22, 1, "R1 p1");
    pulseData(8'h33, 1, "R1 p2"); pulseData(8'h44, 1, "R1 p3");
    pulseStop(1); waitIdle(N, "R7 page busy");
    readAt(8'h9E, 8'h11, "R1 9E");
    readAt(8'h9F, 8'h22, "R1 9F");
    readAt(8'h90, 8'h33, "R1 wrap to 90");
    readAt(8'h91, 8'h44, "R1 91");
    readAt(8'hA0, 8'hFF, "R1 next row untouched");
    readAt(8'h92, 8'hFF, "R9 unwritten slot kept");

    // misaligned stop discards (R2)
    pulseStart(0); pulseAddr(8'hB0); pulseData(8'h77, 1, "R2 data");
    pulseStop(0);
    check("R2 no busy on misaligned stop", busy, 0);
    readAt(8'hB0, 8'hFF, "R2 discarded");

    // repeated start discards (R2)
    pulseStart(0); pulseAddr(8'hE0); pulseData(8'h12, 1, "R2 rs data");
    pulseStart(0); pulseAddr(8'hE1); pulseStop(1);
    check("R2 no busy after restart", busy, 0);
    readAt(8'hE0, 8'hFF, "R2 restart discards");

    // write control high (R3)
    wcIn = 1;
    pulseStart(0); pulseAddr(8'hC0); pulseData(8'h66, 0, "R3 wc mem");
    pulseStop(1);
    check("R3 no commit", busy, 0);
    readAt(8'hC0, 8'hFF, "R3 location kept");
    pulseStart(1); pulseAddr(8'h3C); pulseData(8'hA5, 0, "R3 wc lock sel");
    pulseStop(1);
    wcIn = 0;
    pulseStart(0); pulseAddr(8'h10); pulseData(8'hAB, 1, "R3 lock not set");
    pulseStop(1); waitIdle(N, "R7 busy 10");
    readAt(8'h10, 8'hAB, "R3 lower half writable");

    // set the lock (R5)
    pulseStart(1); pulseAddr(8'h55); pulseData(8'hC3, 1, "R5 lock write");
    pulseStop(1); waitIdle(N, "R5 lock commit busy");

    // locked lower half (R4)
    pulseStart(0); pulseAddr(8'h10); pulseData(8'hCD, 0, "R4 locked low");
    pulseStop(1);
    check("R4 no commit", busy, 0);
    readAt(8'h10, 8'hAB, "R4 kept");
    pulseStart(0); pulseAddr(8'h7F); pulseData(8'h01, 0, "R4 locked 7F");
    pulseStop(1);
    pulseStart(0); pulseAddr(8'h80); pulseData(8'hEE, 1, "R4 upper half");
    pulseStop(1);
    // strobes during busy ignored (R7)
    pulseStart(0); pulseAddr(8'hD0);
    @(negedge clk); dataValid = 1; dataByte = 8'h99;
    @(negedge clk); dataValid = 0;
    check("R11 no ack while busy", ackValid, 0);
    pulseStop(1);
    waitIdle(N - 8, "R7 busy despite strobes");
    readAt(8'h80, 8'hEE, "R4 upper committed");
    readAt(8'hD0, 8'hFF, "R7 ignored write");

    // lock permanent, lock select refused (R6)
    pulseStart(1); pulseAddr(8'h00); pulseData(8'h00, 0, "R6 lock sel refused");
    pulseStop(1);
    check("R6 no commit", busy, 0);

    // reads unaffected by write control and lock (R10)
    wcIn = 1;
    readAt(8'h10, 8'hAB, "R10 read locked wc high");
    readAt(8'h91, 8'h44, "R10 read upper wc high");
    wcIn = 0;
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule